// File: doc/BRIEF.md
# Dual Programmable Clock Divider

This block turns one fast source clock into two slower clocks. The system channel divides by a 5-bit factor. The peripheral channel divides by a 3-bit factor. Both channels run from the same source edge, and each takes its factor from its own input. A factor of zero does not stop or bypass a channel. It selects the largest ratio the field can encode: 32 for the system channel and 8 for the peripheral channel. For example, with a 288 MHz source, factors of 24 and 6 give 12 MHz and 48 MHz.

Each channel produces a divided clock. For ratios of two and above this clock comes from a register, and its high phase is never longer than its low phase. Each channel also produces a one-source-cycle strobe that marks the start of every divided period. A factor of one routes the source clock straight to the output.

A new factor can arrive at any time. The channel takes it in only when its current period ends, so no phase is ever cut short. Reset forces both outputs low.

Top module: `dual_clk_divider`

## Requirements
- R1: With a system factor F from 1 to 31, `sys_clk` repeats every F source cycles, and `sys_stb` is high in exactly one source cycle of each period.
- R2: A system factor of 0 gives a system period of 32 source cycles.
- R3: With a peripheral factor F from 1 to 7, `per_clk` repeats every F source cycles, and `per_stb` is high in exactly one source cycle of each period.
- R4: A peripheral factor of 0 gives a peripheral period of 8 source cycles.
- R5: For a ratio N of 2 or more, the divided clock is high for the first floor(N/2) source cycles of a period and low for the remaining ceil(N/2).
- R6: For a ratio of 1, the divided clock equals the source clock, and the strobe stays high.
- R7: The strobe is high in the source cycle in which the divided clock goes high, and in no other cycle of that period.
- R8: A factor change takes effect only after the current period has completed at its old length. The next period then uses the new ratio.
- R9: While `rst_n` is low, all four outputs are low, even in ratio-1 mode. On the first source edge after release, a period starts with the factor presented at that edge, so both the clock and the strobe go high.
- R10: The two channels share the source clock but run independently; the factor of one channel never changes the waveform of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | Fast source clock feeding both channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_div | input | 5 | System divide factor, 0 selects 32 |
| per_div | input | 3 | Peripheral divide factor, 0 selects 8 |
| sys_clk | output | 1 | Divided system clock |
| sys_stb | output | 1 | One-cycle strobe at each system period start |
| per_clk | output | 1 | Divided peripheral clock |
| per_stb | output | 1 | One-cycle strobe at each peripheral period start |

## Verification
The bench builds the block with its default field widths of 5 and 3 bits. These widths are small enough that every system factor, including zero, can be swept, with a different peripheral factor running alongside each one. The bench compares a whole sampled window of both channels against waveforms it works out from the ratio arithmetic. It changes a factor in the middle of a long period to confirm that the change waits for the period to end. It also checks reset while the block is in pass-through mode.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Ratio selected by a factor field of width w; zero maps to the largest ratio.
  function automatic int unsigned div_ratio(input int unsigned fld, input int unsigned w);
    return (fld == 0) ? (32'd1 << w) : fld;
  endfunction

  // Number of source cycles spent high within one divided period.
  function automatic int unsigned high_len(input int unsigned n);
    return n / 2;
  endfunction
endpackage

// File: rtl/clkdiv_period.sv
module clkdiv_period #(
  parameter int unsigned W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   fld,
  output logic [W:0]     act_o,
  output logic [W:0]     nxt_act_o,
  output logic [W:0]     nxt_cnt_o,
  output logic           wrap_o
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] act_q, cnt_q;
  logic          wrap;
  logic [CW-1:0] nxt_cnt, nxt_act;

  // A period ends on the last count; only then is a new ratio taken in.
  assign wrap    = (cnt_q == act_q - CW'(1));
  assign nxt_cnt = wrap ? '0 : cnt_q + CW'(1);
  assign nxt_act = wrap ? CW'(clkdiv_pkg::div_ratio(int'(fld), W)) : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= CW'(1);
      cnt_q <= '0;
    end else begin
      act_q <= nxt_act;
      cnt_q <= nxt_cnt;
    end
  end

  assign act_o     = act_q;
  assign nxt_act_o = nxt_act;
  assign nxt_cnt_o = nxt_cnt;
  assign wrap_o    = wrap;

  // R8: ratio only moves at a period boundary
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));
  // R1: counter stays inside the active period
  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);
  // R2: a zero factor never yields a zero ratio
  a_r2_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    act_q != '0);
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave #(
  parameter int unsigned W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [W:0] nxt_act,
  input  logic [W:0] nxt_cnt,
  output logic       clk_o,
  output logic       stb_o,
  output logic       byp_o
);
  logic div_q, stb_q, byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      stb_q <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      div_q <= int'(nxt_cnt) < int'(clkdiv_pkg::high_len(int'(nxt_act)));
      stb_q <= (nxt_cnt == '0);
      byp_q <= (int'(nxt_act) == 1);
    end
  end

  // Ratio one hands the source clock straight out; reset clears byp_q so it stays low.
  assign clk_o = byp_q ? clk : div_q;
  assign stb_o = stb_q;
  assign byp_o = byp_q;

  // R6: pass-through mode strobes every cycle
  a_r6_bypass_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> stb_q);
  // R7: when dividing, the strobe coincides with the high phase start
  a_r7_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !byp_q) |-> div_q);
  // R5: the falling edge of the divided clock is never a period start
  a_r5_fall_not_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_q) |-> !stb_q);
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fld,
  output logic         clk_o,
  output logic         stb_o
);
  logic [W:0] act, nxt_act, nxt_cnt;
  logic       wrap, byp;

  clkdiv_period #(.W(W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld       (fld),
    .act_o     (act),
    .nxt_act_o (nxt_act),
    .nxt_cnt_o (nxt_cnt),
    .wrap_o    (wrap)
  );

  clkdiv_wave #(.W(W)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_act (nxt_act),
    .nxt_cnt (nxt_cnt),
    .clk_o   (clk_o),
    .stb_o   (stb_o),
    .byp_o   (byp)
  );

  // R7: a strobe lasts one source cycle when the ratio is at least two
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && int'(act) >= 2) |=> !stb_o);
  // R6: pass-through flag tracks a ratio of one
  a_r6_bypass_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    byp |-> (int'(act) == 1));
  // R8: a strobe always follows a completed period
  a_r8_strobe_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> stb_o);
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider #(
  parameter int unsigned SYS_W = 5,
  parameter int unsigned PER_W = 3
) (
  input  logic             pll_clk,
  input  logic             rst_n,
  input  logic [SYS_W-1:0] sys_div,
  input  logic [PER_W-1:0] per_div,
  output logic             sys_clk,
  output logic             sys_stb,
  output logic             per_clk,
  output logic             per_stb
);
  // R10: two independent channels on one source edge
  clkdiv_chan #(.W(SYS_W)) u_sys (
    .clk   (pll_clk),
    .rst_n (rst_n),
    .fld   (sys_div),
    .clk_o (sys_clk),
    .stb_o (sys_stb)
  );

  clkdiv_chan #(.W(PER_W)) u_per (
    .clk   (pll_clk),
    .rst_n (rst_n),
    .fld   (per_div),
    .clk_o (per_clk),
    .stb_o (per_stb)
  );
endmodule

// File: tb/sim_dual_clk_divider.sv
module sim_dual_clk_divider;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [4:0] sd = 5'd24;
  logic [2:0] pd = 3'd6;
  logic sys_clk, sys_stb, per_clk, per_stb;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic sa [0:79];
  logic sb [0:79];
  logic pa [0:79];
  logic pb [0:79];

  dual_clk_divider u0 (
    .pll_clk (clk), .rst_n (rst_n), .sys_div (sd), .per_div (pd),
    .sys_clk (sys_clk), .sys_stb (sys_stb), .per_clk (per_clk), .per_stb (per_stb)
  );

  function automatic int ratio(input int f, input int w);
    return (f == 0) ? (1 << w) : f;
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic grab();
    for (int k = 0; k < 80; k++) begin
      @(negedge clk); #1;
      sa[k] = sys_clk; sb[k] = sys_stb; pa[k] = per_clk; pb[k] = per_stb;
    end
  endtask

  // Compare one channel's sampled window with the arithmetic waveform for ratio n.
  task automatic verify(input string req, input bit isper, input int n);
    int s = -1, bad = 0, first = -1, actv = 0, expv = 0;
    for (int k = 0; k < 80; k++)
      if (s < 0 && (isper ? pb[k] : sb[k])) s = k;
    if (s < 0 || s >= n) begin
      note(1'b0, req, "first strobe index", s, n - 1);
      return;
    end
    for (int k = s; k < 80; k++) begin
      int j = (k - s) % n;
      logic ec = (j < n / 2);
      logic es = (j == 0);
      logic ac = isper ? pa[k] : sa[k];
      logic as_ = isper ? pb[k] : sb[k];
      if (ac !== ec || as_ !== es) begin
        bad++;
        if (first < 0) begin
          first = k; actv = {ac, as_}; expv = {ec, es};
        end
      end
    end
    note(bad == 0, req, $sformatf("ratio %0d window at %0d {clk,stb}", n, first), actv, expv);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: outputs low under reset
    sd = 5'd3; pd = 3'd2;
    repeat (3) @(negedge clk);
    #1;
    note({sys_clk, sys_stb, per_clk, per_stb} == 4'b0, "R9", "outputs in reset",
         {sys_clk, sys_stb, per_clk, per_stb}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    note(sys_clk && sys_stb, "R9", "system start after release", {sys_clk, sys_stb}, 3);
    note(per_clk && per_stb, "R9", "peripheral start after release", {per_clk, per_stb}, 3);

    // R1 R2 R3 R4 R5 R7 R10: sweep every system factor with a varying peripheral factor
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      sd = 5'(i);
      pd = 3'((i * 3) % 8);
      repeat (70) @(negedge clk);
      grab();
      verify((i == 0) ? "R2" : ((i == 1) ? "R6" : "R1/R5/R7"), 1'b0, ratio(i, 5));
      verify((((i * 3) % 8) == 0) ? "R4" : "R3/R10", 1'b1, ratio((i * 3) % 8, 3));
    end

    // R6: pass-through follows the source high phase too
    @(negedge clk); sd = 5'd1;
    repeat (40) @(negedge clk);
    @(posedge clk); #2;
    note(sys_clk === 1'b1 && sys_stb === 1'b1, "R6", "pass-through high phase",
         {sys_clk, sys_stb}, 3);
    @(negedge clk); #1;
    note(sys_clk === 1'b0, "R6", "pass-through low phase", sys_clk, 0);

    // R8: change the factor just after a period start; old period must finish
    @(negedge clk); sd = 5'd24;
    repeat (70) @(negedge clk);
    begin
      int guard = 0;
      do begin
        @(negedge clk); #1; guard++;
      end while (!sys_stb && guard < 60);
      sd = 5'd5;
      begin
        int bad = 0;
        for (int k = 1; k < 60; k++) begin
          logic ec, es;
          @(negedge clk); #1;
          if (k < 24) begin
            ec = (k < 12); es = 1'b0;
          end else begin
            ec = ((k - 24) % 5) < 2; es = ((k - 24) % 5) == 0;
          end
          if (sys_clk !== ec || sys_stb !== es) bad++;
        end
        note(bad == 0, "R8", "mismatched cycles around factor change", bad, 0);
      end
    end

    // R9: reset forces a pass-through output low while the source is high
    @(negedge clk); sd = 5'd1;
    repeat (40) @(negedge clk);
    @(posedge clk); #2;
    rst_n = 1'b0; #1;
    note(sys_clk === 1'b0 && sys_stb === 1'b0, "R9", "pass-through under reset",
         {sys_clk, sys_stb}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule